// File: doc/BRIEF.md
# DRAM Burst Cycle Sequencer

This block sequences fast-page-mode DRAM cycles. It drives the row strobe, the column strobe, the write enable, a row/column address select and a multiplexed memory address for four kinds of cycle: four-beat burst reads, four-beat burst writes, single writes and refresh. Each request carries an address, a cycle kind and a flag that marks it as coming from the processor or from some other bus master, such as a second bus master, an expansion-bus master or a DMA channel. The block returns a strobe for each transfer and a strobe that marks the end of the cycle.

Cycle timing is programmable. Burst-read, burst-write and single-write lengths come from two independent mode sets: one for processor cycles and one for other masters. The flag on each request chooses the set. The row-to-column delay, the precharge time and the refresh pulse width are shared by both sets. All mode inputs are captured when a request is accepted, so a change made mid-cycle only affects later cycles.

For writes from other masters, the block computes the byte-lane parity itself. For processor writes, it passes the parity supplied with the request through unchanged.

Top module: `dram_burst_seq`

## Requirements
- R1: After reset `req_ready` is 1, `ras_n`, `cas_n` and `dwe_n` are 1, and `beat_rdy` and `cyc_end` are 0. While idle the strobes stay high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. For a non-refresh cycle, the next clocks are a row phase lasting 1 clock (`rc_long`=0) or 2 clocks (`rc_long`=1). In the row phase `ras_n`=0, `cas_n`=1, `col_sel`=0 and `ma` holds address bits [19:10].
- R3: Burst read (`req_kind`=0) has four beats after the row phase. Their lengths are set by the 2-bit read mode: 0 gives 3,2,2,2 clocks; 1 gives 4,3,3,3; 2 gives 5,4,4,4. Code 3 behaves as 2.
- R4: Burst write (`req_kind`=1) has four beats of 3,2,2,2 clocks (write mode 0) or 4,3,3,3 clocks (write mode 1). `dwe_n` is 0 for the whole column phase of any write and 1 during reads.
- R5: Single write (`req_kind`=2) is one beat of 2 clocks (wait-state bit 0) or 3 clocks (wait-state bit 1).
- R6: During the column phase `ras_n`=0 and `col_sel`=1. `cas_n`=0 and `beat_rdy`=1 only on the final clock of each beat. `cyc_end` pulses with the last `beat_rdy`. `ma` equals {address[9:2], address[1:0]+beat index mod 4}.
- R7: `req_alt`=0 selects the `cpu_*` mode inputs and `req_alt`=1 selects the `alt_*` inputs, for read, write and single-write timing.
- R8: After the cycle, `ras_n` stays 1 for 2 clocks (`pre_long`=0) or 3 clocks (`pre_long`=1) before it can fall again. `req_ready` returns to 1 on the last of those clocks.
- R9: Refresh (`req_kind`=3) is CAS-before-RAS. `cas_n` falls one clock before `ras_n`. Both then stay 0 for 3 clocks (`ref_long`=0) or 4 clocks (`ref_long`=1). `cyc_end` is on the last of those clocks. `dwe_n` stays 1 and `beat_rdy` stays 0.
- R10: From the clock after acceptance of a write, `wpar_out` bit i is the XOR of `req_wdata` byte i when `req_alt`=1 (even parity per lane). When `req_alt`=0 it is the `req_wpar` captured with the request.
- R11: Mode inputs are sampled only at acceptance. Changing them during a cycle does not alter that cycle's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd_mode | input | 2 | Processor burst-read mode |
| cpu_wr_slow | input | 1 | Processor burst-write mode |
| cpu_sw_ws | input | 1 | Processor single-write wait state |
| alt_rd_mode | input | 2 | Other-master burst-read mode |
| alt_wr_slow | input | 1 | Other-master burst-write mode |
| alt_sw_ws | input | 1 | Other-master single-write wait state |
| rc_long | input | 1 | Long row-to-column delay |
| pre_long | input | 1 | Long precharge |
| ref_long | input | 1 | Long refresh row pulse |
| req_valid | input | 1 | Request present |
| req_alt | input | 1 | Request is from a non-processor master |
| req_kind | input | 2 | 0 burst read, 1 burst write, 2 single write, 3 refresh |
| req_addr | input | 20 | Request address, row in upper half |
| req_wdata | input | 32 | Write data |
| req_wpar | input | 4 | Parity supplied with processor writes |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| dwe_n | output | 1 | Write enable, active low |
| col_sel | output | 1 | 1 when `ma` carries a column |
| ma | output | 10 | Multiplexed memory address |
| wpar_out | output | 4 | Parity for the write data lanes |
| beat_rdy | output | 1 | One transfer completes |
| cyc_end | output | 1 | Last clock of the cycle |

## Verification
A wrong count or beat index shows up at once as a shifted `beat_rdy`/`cas_n` edge, or as a column address that is off by one within the same beat. A wrong state transition shows up within one clock as a strobe at the wrong level. A stale mode latch changes the length of the very cycle in which the inputs move. A shortened precharge shows as `req_ready` rising a clock early, before the next row strobe could fall. Parity faults appear on `wpar_out` the clock after acceptance.

// File: rtl/dbs_pkg.sv
`timescale 1ns/1ps
// Shared types for the DRAM burst sequencer.
// Assumes beat counts never exceed 7 clocks, so a 3-bit counter suffices.
package dbs_pkg;
    localparam int CNT_W = 3;

    typedef enum logic [1:0] {
        K_BRD = 2'd0,
        K_BWR = 2'd1,
        K_SWR = 2'd2,
        K_REF = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROW,
        S_COL,
        S_PRE,
        S_RCAS,
        S_RRAS
    } st_e;

    // Resolved timing of one cycle
    typedef struct packed {
        logic [CNT_W-1:0] first;  // first beat length, or refresh row pulse width
        logic [CNT_W-1:0] next;   // length of beats two to four
        logic             burst;  // four beats instead of one
        logic             wr;     // write cycle
        logic             refr;   // refresh cycle
    } tim_s;
endpackage

// File: rtl/dbs_mode_sel.sv
`timescale 1ns/1ps
// Chooses the mode set by master type and turns the mode codes into clock
// counts for the requested cycle kind. Purely combinational.
// Assumes a read mode code of 3 is to be treated as the slowest mode.
module dbs_mode_sel
    import dbs_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       alt,
    input  logic [1:0] cpu_rd_mode,
    input  logic       cpu_wr_slow,
    input  logic       cpu_sw_ws,
    input  logic [1:0] alt_rd_mode,
    input  logic       alt_wr_slow,
    input  logic       alt_sw_ws,
    input  logic       ref_long,
    output tim_s       tim
);
    logic [1:0] rd_code;
    logic [1:0] rd_sat;
    logic       wr_slow;
    logic       sw_ws;

    // Pick the mode set for this master
    always_comb begin
        rd_code = alt ? alt_rd_mode : cpu_rd_mode;
        wr_slow = alt ? alt_wr_slow : cpu_wr_slow;
        sw_ws   = alt ? alt_sw_ws   : cpu_sw_ws;
        rd_sat  = (rd_code == 2'd3) ? 2'd2 : rd_code;
    end

    // Translate mode codes into beat lengths
    always_comb begin
        tim = '0;
        case (kind_e'(kind))
            K_BRD: begin
                tim.first = 3'd3 + {1'b0, rd_sat};
                tim.next  = 3'd2 + {1'b0, rd_sat};
                tim.burst = 1'b1;
            end
            K_BWR: begin
                tim.first = 3'd3 + {2'b00, wr_slow};
                tim.next  = 3'd2 + {2'b00, wr_slow};
                tim.burst = 1'b1;
                tim.wr    = 1'b1;
            end
            K_SWR: begin
                tim.first = 3'd2 + {2'b00, sw_ws};
                tim.next  = 3'd2 + {2'b00, sw_ws};
                tim.wr    = 1'b1;
            end
            default: begin
                tim.first = 3'd3 + {2'b00, ref_long};
                tim.next  = 3'd3 + {2'b00, ref_long};
                tim.refr  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dbs_parity.sv
`timescale 1ns/1ps
// Per-lane parity source: even parity over each byte when the block makes
// its own parity, otherwise the externally supplied bits.
// Assumes DATA_W is a multiple of eight.
module dbs_parity #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic              gen,
    input  logic [DATA_W-1:0] data,
    input  logic [LANES-1:0]  par_in,
    output logic [LANES-1:0]  par_out
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // One lane: XOR of its byte makes the lane's one-count even
            assign par_out[g] = gen ? ^data[8*g +: 8] : par_in[g];
        end
    endgenerate
endmodule

// File: rtl/dbs_fsm.sv
`timescale 1ns/1ps
// Cycle state machine: row phase, column beats, refresh and precharge.
// Captures the resolved timing plus the delay and precharge settings at
// acceptance, so later mode changes do not disturb a running cycle.
// Assumes every beat is at least two clocks long.
module dbs_fsm
    import dbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  tim_s       tim_in,
    input  logic       rc_long,
    input  logic       pre_long,
    output logic       idle,
    output logic       ras_n,
    output logic       cas_n,
    output logic       dwe_n,
    output logic       col_sel,
    output logic [1:0] beat,
    output logic       beat_rdy,
    output logic       cyc_end
);
    st_e              st;
    logic [CNT_W-1:0] cnt;
    tim_s             tl;
    logic             pre_l;
    logic             cnt_zero;
    logic             last_beat;
    logic [CNT_W-1:0] pre_load;

    assign cnt_zero  = (cnt == '0);
    assign last_beat = !tl.burst || (beat == 2'd3);
    assign pre_load  = pre_l ? CNT_W'(1) : CNT_W'(0);

    // Sequence the states and count clocks within each phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            cnt   <= '0;
            beat  <= 2'd0;
            tl    <= '0;
            pre_l <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (accept) begin
                        tl    <= tim_in;
                        pre_l <= pre_long;
                        beat  <= 2'd0;
                        if (tim_in.refr) begin
                            st  <= S_RCAS;
                            cnt <= '0;
                        end else begin
                            st  <= S_ROW;
                            cnt <= rc_long ? CNT_W'(1) : CNT_W'(0);
                        end
                    end
                end
                S_ROW: begin
                    if (cnt_zero) begin
                        st  <= S_COL;
                        cnt <= tl.first - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                S_COL: begin
                    if (cnt_zero) begin
                        if (last_beat) begin
                            st  <= S_PRE;
                            cnt <= pre_load;
                        end else begin
                            beat <= beat + 2'd1;
                            cnt  <= tl.next - CNT_W'(1);
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                S_PRE: begin
                    if (cnt_zero) st <= S_IDLE;
                    else          cnt <= cnt - CNT_W'(1);
                end
                S_RCAS: begin
                    st  <= S_RRAS;
                    cnt <= tl.first - CNT_W'(1);
                end
                S_RRAS: begin
                    if (cnt_zero) begin
                        st  <= S_PRE;
                        cnt <= pre_load;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Decode strobes from the state and the phase counter
    always_comb begin
        idle     = (st == S_IDLE);
        ras_n    = !((st == S_ROW) || (st == S_COL) || (st == S_RRAS));
        cas_n    = !(((st == S_COL) && cnt_zero) || (st == S_RCAS) || (st == S_RRAS));
        dwe_n    = !((st == S_COL) && tl.wr);
        col_sel  = (st == S_COL);
        beat_rdy = (st == S_COL) && cnt_zero;
        cyc_end  = (beat_rdy && last_beat) || ((st == S_RRAS) && cnt_zero);
    end
endmodule

// File: rtl/dram_burst_seq.sv
`timescale 1ns/1ps
// DRAM burst cycle sequencer top. Accepts one request when idle, resolves
// its timing from the mode set of its master, latches address and write
// parity, and multiplexes row and column onto the memory address.
// Assumes the address is split into equal row and column halves.
module dram_burst_seq
    import dbs_pkg::*;
#(
    parameter int MA_W   = 10,
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int ADDR_W = 2 * MA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cpu_rd_mode,
    input  logic              cpu_wr_slow,
    input  logic              cpu_sw_ws,
    input  logic [1:0]        alt_rd_mode,
    input  logic              alt_wr_slow,
    input  logic              alt_sw_ws,
    input  logic              rc_long,
    input  logic              pre_long,
    input  logic              ref_long,
    input  logic              req_valid,
    input  logic              req_alt,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_wpar,
    output logic              req_ready,
    output logic              ras_n,
    output logic              cas_n,
    output logic              dwe_n,
    output logic              col_sel,
    output logic [MA_W-1:0]   ma,
    output logic [LANES-1:0]  wpar_out,
    output logic              beat_rdy,
    output logic              cyc_end
);
    tim_s              tim;
    logic              idle;
    logic              accept;
    logic [1:0]        beat;
    logic [LANES-1:0]  par_next;
    logic [ADDR_W-1:0] addr_l;

    assign req_ready = idle;
    assign accept    = req_valid && idle;

    dbs_mode_sel u_mode (
        .kind        (req_kind),
        .alt         (req_alt),
        .cpu_rd_mode (cpu_rd_mode),
        .cpu_wr_slow (cpu_wr_slow),
        .cpu_sw_ws   (cpu_sw_ws),
        .alt_rd_mode (alt_rd_mode),
        .alt_wr_slow (alt_wr_slow),
        .alt_sw_ws   (alt_sw_ws),
        .ref_long    (ref_long),
        .tim         (tim)
    );

    dbs_parity #(.DATA_W(DATA_W)) u_par (
        .gen     (req_alt),
        .data    (req_wdata),
        .par_in  (req_wpar),
        .par_out (par_next)
    );

    dbs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .tim_in   (tim),
        .rc_long  (rc_long),
        .pre_long (pre_long),
        .idle     (idle),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .dwe_n    (dwe_n),
        .col_sel  (col_sel),
        .beat     (beat),
        .beat_rdy (beat_rdy),
        .cyc_end  (cyc_end)
    );

    // Hold address and write parity for the duration of the cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_l   <= '0;
            wpar_out <= '0;
        end else if (accept) begin
            addr_l   <= req_addr;
            wpar_out <= par_next;
        end
    end

    // Row half in the row phase, column half with beat-stepped low bits after
    always_comb begin
        if (col_sel) ma = {addr_l[MA_W-1:2], addr_l[1:0] + beat};
        else         ma = addr_l[ADDR_W-1:MA_W];
    end
endmodule

// File: rtl/dbs_checks.sv
`timescale 1ns/1ps
// Protocol checker for the DRAM burst sequencer, bound to the top module.
// Assumes the synchronous active-low reset is asserted from time zero.
module dbs_checks #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_alt,
    input logic [1:0]        req_kind,
    input logic [DATA_W-1:0] req_wdata,
    input logic [LANES-1:0]  req_wpar,
    input logic              ras_n,
    input logic              cas_n,
    input logic              dwe_n,
    input logic              beat_rdy,
    input logic              cyc_end,
    input logic [LANES-1:0]  wpar_out
);
    function automatic logic [LANES-1:0] lane_par(input logic [DATA_W-1:0] d);
        logic [LANES-1:0] p;
        for (int i = 0; i < LANES; i++) p[i] = ^d[8*i +: 8];
        return p;
    endfunction

    logic wr_take;
    assign wr_take = req_valid && req_ready && (req_kind == 2'd1 || req_kind == 2'd2);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ras_n && cas_n && dwe_n && !beat_rdy && !cyc_end));

    a_r6_rdy_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        beat_rdy |-> (!cas_n && !ras_n));

    a_r6_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
        beat_rdy |=> !beat_rdy);

    a_r4_dwe_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        !dwe_n |-> !ras_n);

    a_r8_end_release: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> (ras_n && !req_ready));

    a_r8_pre_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);

    a_r9_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

    a_r10_alt_par: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && req_alt) |=> (wpar_out == lane_par($past(req_wdata))));

    a_r10_cpu_par: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && !req_alt) |=> (wpar_out == $past(req_wpar)));
endmodule

bind dram_burst_seq dbs_checks #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_alt   (req_alt),
    .req_kind  (req_kind),
    .req_wdata (req_wdata),
    .req_wpar  (req_wpar),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .dwe_n     (dwe_n),
    .beat_rdy  (beat_rdy),
    .cyc_end   (cyc_end),
    .wpar_out  (wpar_out)
);

// File: tb/tb_dram_burst_seq.sv
`timescale 1ns/1ps
module tb_dram_burst_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cpu_rd_mode = 2'd0;
    logic        cpu_wr_slow = 1'b0;
    logic        cpu_sw_ws = 1'b0;
    logic [1:0]  alt_rd_mode = 2'd0;
    logic        alt_wr_slow = 1'b0;
    logic        alt_sw_ws = 1'b0;
    logic        rc_long = 1'b0;
    logic        pre_long = 1'b0;
    logic        ref_long = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_alt = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_wpar = '0;
    logic        req_ready, ras_n, cas_n, dwe_n, col_sel, beat_rdy, cyc_end;
    logic [9:0]  ma;
    logic [3:0]  wpar_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dram_burst_seq dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_rd_mode(cpu_rd_mode), .cpu_wr_slow(cpu_wr_slow), .cpu_sw_ws(cpu_sw_ws),
        .alt_rd_mode(alt_rd_mode), .alt_wr_slow(alt_wr_slow), .alt_sw_ws(alt_sw_ws),
        .rc_long(rc_long), .pre_long(pre_long), .ref_long(ref_long),
        .req_valid(req_valid), .req_alt(req_alt), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wpar(req_wpar),
        .req_ready(req_ready), .ras_n(ras_n), .cas_n(cas_n), .dwe_n(dwe_n),
        .col_sel(col_sel), .ma(ma), .wpar_out(wpar_out),
        .beat_rdy(beat_rdy), .cyc_end(cyc_end)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Issue one request and compare every clock against the requirement model
    task automatic run_cycle(input string tag, input logic alt, input logic [1:0] kind,
                             input logic [19:0] addr, input logic [31:0] wd,
                             input logic [3:0] wp, input bit mid_change);
        int L[4];
        int nb, rc, P, W, T, rd, e_wave, e_rdy, e_ready, e_addr, n_rdy, n_end;
        bit wr, refr;
        logic [3:0] x_par;
        logic [1:0] save_cpu_rd, save_alt_rd;
        logic save_wr, save_aw;
        rd = alt ? alt_rd_mode : cpu_rd_mode;
        if (rd == 3) rd = 2;
        wr = (kind == 2'd1) || (kind == 2'd2);
        refr = (kind == 2'd3);
        rc = rc_long ? 2 : 1;
        P = pre_long ? 3 : 2;
        W = ref_long ? 4 : 3;
        nb = 4;
        case (kind)
            2'd0: begin L[0] = 3 + rd; for (int i = 1; i < 4; i++) L[i] = 2 + rd; end
            2'd1: begin
                L[0] = 3 + int'(alt ? alt_wr_slow : cpu_wr_slow);
                for (int i = 1; i < 4; i++) L[i] = L[0] - 1;
            end
            2'd2: begin nb = 1; L[0] = 2 + int'(alt ? alt_sw_ws : cpu_sw_ws); end
            default: begin nb = 0; end
        endcase
        if (refr) T = W + 1;
        else begin
            T = rc;
            for (int i = 0; i < nb; i++) T += L[i];
        end
        for (int i = 0; i < 4; i++) x_par[i] = alt ? ^wd[8*i +: 8] : wp[i];
        e_wave = 0; e_rdy = 0; e_ready = 0; e_addr = 0; n_rdy = 0; n_end = 0;
        save_cpu_rd = cpu_rd_mode; save_alt_rd = alt_rd_mode;
        save_wr = cpu_wr_slow; save_aw = alt_wr_slow;

        req_alt = alt; req_kind = kind; req_addr = addr; req_wdata = wd; req_wpar = wp;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= T + P; k++) begin
            logic x_ras, x_cas, x_dwe, x_sel, x_rdy, x_end, x_rq;
            logic [9:0] x_ma;
            bit use_ma;
            int j, acc;
            x_ras = 1; x_cas = 1; x_dwe = 1; x_sel = 0; x_rdy = 0; x_end = 0;
            x_ma = '0; use_ma = 0;
            x_rq = (k == T + P);
            if (refr) begin
                if (k == 1) x_cas = 0;
                else if (k <= W + 1) begin x_ras = 0; x_cas = 0; x_end = (k == W + 1); end
            end else if (k <= rc) begin
                x_ras = 0; use_ma = 1; x_ma = addr[19:10];
            end else if (k <= T) begin
                j = k - rc; acc = 0;
                for (int b = 0; b < nb; b++) begin
                    if (j > acc && j <= acc + L[b]) begin
                        x_ras = 0; x_sel = 1; x_dwe = !wr;
                        x_rdy = (j == acc + L[b]); x_cas = !x_rdy;
                        x_end = x_rdy && (b == nb - 1);
                        use_ma = 1;
                        x_ma = {addr[9:2], 2'(addr[1:0] + 2'(b))};
                    end
                    acc += L[b];
                end
            end
            if (ras_n !== x_ras || cas_n !== x_cas || dwe_n !== x_dwe || col_sel !== x_sel) e_wave++;
            if (beat_rdy !== x_rdy || cyc_end !== x_end) e_rdy++;
            if (req_ready !== x_rq) e_ready++;
            if (use_ma && ma !== x_ma) e_addr++;
            if (beat_rdy === 1'b1) n_rdy++;
            if (cyc_end === 1'b1) n_end++;
            if (k == 1 && wr) check(wpar_out === x_par, "R10", {tag, " parity"}, int'(wpar_out), int'(x_par));
            if (k == 1 && mid_change) begin
                cpu_rd_mode = 2'd1; alt_rd_mode = 2'd0;
                cpu_wr_slow = ~cpu_wr_slow; alt_wr_slow = ~alt_wr_slow;
            end
            @(negedge clk);
        end
        if (mid_change) begin
            cpu_rd_mode = save_cpu_rd; alt_rd_mode = save_alt_rd;
            cpu_wr_slow = save_wr; alt_wr_slow = save_aw;
        end
        check(e_wave == 0, tag, "strobe waveform mismatching clocks", e_wave, 0);
        check(e_rdy == 0, tag, "beat_rdy/cyc_end mismatching clocks", e_rdy, 0);
        check(n_rdy == nb, tag, "beat_rdy count", n_rdy, nb);
        check(n_end == 1, tag, "cyc_end count", n_end, 1);
        check(e_ready == 0, "R8", {tag, " req_ready timing"}, e_ready, 0);
        if (!refr) check(e_addr == 0, "R2/R6", {tag, " ma mismatching clocks"}, e_addr, 0);
    endtask

    task automatic t_reset();
        // R1: quiet idle outputs after reset
        check(req_ready === 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
        check({ras_n, cas_n, dwe_n} === 3'b111, "R1", "strobes after reset",
              int'({ras_n, cas_n, dwe_n}), 7);
        check({beat_rdy, cyc_end} === 2'b00, "R1", "rdy/end after reset",
              int'({beat_rdy, cyc_end}), 0);
    endtask

    task automatic t_read_modes();
        for (int m = 0; m < 4; m++) begin
            cpu_rd_mode = 2'(m);
            run_cycle("R3 R6 read", 1'b0, 2'd0, 20'hABC01 + 20'(m), 32'h0, 4'h0, 1'b0);
        end
        cpu_rd_mode = 2'd0;
    endtask

    task automatic t_write_modes();
        for (int m = 0; m < 2; m++) begin
            cpu_wr_slow = 1'(m);
            run_cycle("R4 R6 write", 1'b0, 2'd1, 20'h12347, 32'h1234_5678, 4'h9, 1'b0);
        end
        cpu_wr_slow = 1'b0;
    endtask

    task automatic t_single_write();
        for (int m = 0; m < 2; m++) begin
            cpu_sw_ws = 1'(m);
            run_cycle("R5 single", 1'b0, 2'd2, 20'h5A5A2, 32'hDEAD_BEEF, 4'h6, 1'b0);
        end
        cpu_sw_ws = 1'b0;
    endtask

    task automatic t_row_delay();
        rc_long = 1'b1;
        run_cycle("R2 long row delay", 1'b0, 2'd0, 20'hFF003, 32'h0, 4'h0, 1'b0);
        rc_long = 1'b0;
    endtask

    task automatic t_precharge();
        pre_long = 1'b1;
        run_cycle("R8 long precharge", 1'b0, 2'd2, 20'h00010, 32'h0000_00FF, 4'h1, 1'b0);
        pre_long = 1'b0;
    endtask

    task automatic t_refresh();
        for (int m = 0; m < 2; m++) begin
            ref_long = 1'(m);
            run_cycle("R9 refresh", 1'b0, 2'd3, 20'h0, 32'h0, 4'h0, 1'b0);
        end
        ref_long = 1'b0;
    endtask

    task automatic t_alt_set();
        cpu_rd_mode = 2'd0; cpu_wr_slow = 1'b0; cpu_sw_ws = 1'b0;
        alt_rd_mode = 2'd2; alt_wr_slow = 1'b1; alt_sw_ws = 1'b1;
        run_cycle("R7 alt read", 1'b1, 2'd0, 20'h31410, 32'h0, 4'h0, 1'b0);
        run_cycle("R7 R10 alt write", 1'b1, 2'd1, 20'h27182, 32'h0301_FF07, 4'h0, 1'b0);
        run_cycle("R7 R10 alt single", 1'b1, 2'd2, 20'h16180, 32'h8000_0001, 4'hF, 1'b0);
        run_cycle("R7 cpu read", 1'b0, 2'd0, 20'h31411, 32'h0, 4'h0, 1'b0);
        alt_rd_mode = 2'd0; alt_wr_slow = 1'b0; alt_sw_ws = 1'b0;
    endtask

    task automatic t_mid_change();
        cpu_rd_mode = 2'd2;
        run_cycle("R11 read mode change", 1'b0, 2'd0, 20'h44443, 32'h0, 4'h0, 1'b1);
        cpu_wr_slow = 1'b0;
        run_cycle("R11 write mode change", 1'b0, 2'd1, 20'h55550, 32'hCAFE_0000, 4'h3, 1'b1);
        cpu_rd_mode = 2'd0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_modes();
        t_write_modes();
        t_single_write();
        t_row_delay();
        t_precharge();
        t_refresh();
        t_alt_set();
        t_mid_change();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule